// File: doc/BRIEF.md
# Quadword-to-Word Memory Write Bridge

This block takes a stream of 128-bit beats, offered with a valid/ready handshake and a flag on the final beat of each packet, and turns every accepted beat into four 32-bit full-word writes on a single-cycle write strobe port. The lowest 32-bit lane of the beat is written first and the highest last. Each word goes to the next sequential word address, starting from a base address fixed by a parameter.

Every write carries a constant requester identifier, also fixed by a parameter, so that the memory side can attribute the traffic. The beat is captured when it is accepted. While its four writes are being issued, the stream is held off. When the writes of a beat flagged as last have finished, the address counter goes back to the base address, so the next packet starts there again.

Top module: `qw_word_bridge`

## Requirements
- R1: Immediately after reset, `in_ready` is 1, `wr_en` is 0, and the next write address is the base address.
- R2: A beat accepted on a clock edge, with `in_valid` and `in_ready` both high, produces exactly four write strobes. They fall in the four cycles that directly follow that edge, with no gap between them.
- R3: The lanes are written in little-endian order: bits [31:0] first, then [63:32], then [95:64], then [127:96].
- R4: The first write after reset or after a packet end goes to the base address. Every later write goes 4 bytes above the one before it, and this stays true across beats of the same packet.
- R5: `wr_be` is 4'b1111 on every write.
- R6: `wr_id` equals the requester identifier parameter (default 3) on every write.
- R7: `in_ready` is 0 in every cycle where a write of the current beat is being issued. It is 1 again in the cycle after the fourth write.
- R8: After the fourth write of a beat that was accepted with `in_last` = 1, the next write goes back to the base address.
- R9: When no beat is being unpacked, `wr_en` stays 0.
- R10: The written data comes from the beat as it was at acceptance. Changes to `in_data` or `in_last` after acceptance have no effect on that beat's writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Stream beat offered |
| in_data | input | 128 | Stream beat payload |
| in_last | input | 1 | Beat is the final one of its packet |
| in_ready | output | 1 | Bridge can accept a beat |
| wr_en | output | 1 | Single-cycle write strobe |
| wr_addr | output | 32 | Byte address of the word being written |
| wr_data | output | 32 | Word being written |
| wr_be | output | 4 | Byte enables, all set |
| wr_id | output | 8 | Fixed requester identifier |

## Verification
The bench goes after lane order and address stepping across several multi-beat packets. A swapped lane index or a missing step would show up as a wrong word or a repeated address. It holds `in_valid` high across a busy period with a new beat: a bridge that accepted early would lose or overwrite the beat in flight. It also changes `in_data` after acceptance, which catches a design that reads the live bus instead of a captured copy. Packet ends and a reset in the middle of a packet are checked for a return to the base address; a design that only rewinds on reset, or never rewinds, would keep counting upward.

// File: rtl/qwb_pkg.sv
package qwb_pkg;

    localparam int IN_W   = 128;
    localparam int OUT_W  = 32;
    localparam int LANES  = IN_W / OUT_W;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int BE_W   = OUT_W / 8;

    typedef struct packed {
        logic              busy;
        logic [LANE_W-1:0] lane;
        logic              last;
        logic [IN_W-1:0]   beat;
    } qwb_state_t;

endpackage

// File: rtl/qwb_lane_mux.sv
module qwb_lane_mux
    import qwb_pkg::*;
(
    input  logic [IN_W-1:0]   beat,
    input  logic [LANE_W-1:0] sel,
    output logic [OUT_W-1:0]  word
);

    logic [OUT_W-1:0] lane_words [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_words[g] = beat[g*OUT_W +: OUT_W];
    end

    assign word = lane_words[sel];

endmodule

// File: rtl/qwb_addr_gen.sv
module qwb_addr_gen #(
    parameter int                ADDR_W    = 32,
    parameter int                STEP      = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              rewind,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (rewind) begin
            addr_d = BASE_ADDR;
        end else if (step) begin
            addr_d = addr_q + ADDR_W'(STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= BASE_ADDR;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/qw_word_bridge.sv
module qw_word_bridge
    import qwb_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                ID_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter logic [ID_W-1:0]   REQ_ID    = 8'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [OUT_W-1:0]  wr_data,
    output logic [BE_W-1:0]   wr_be,
    output logic [ID_W-1:0]   wr_id
);

    localparam logic [LANE_W-1:0] FINAL_LANE = LANE_W'(LANES - 1);

    qwb_state_t st_d, st_q;
    logic       accept;
    logic       lane_done;
    logic       rewind;

    assign accept    = in_valid && !st_q.busy;
    assign lane_done = st_q.busy && (st_q.lane == FINAL_LANE);
    assign rewind    = lane_done && st_q.last;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            st_d.lane = st_q.lane + LANE_W'(1);
            if (lane_done) begin
                st_d.busy = 1'b0;
                st_d.lane = '0;
            end
        end else if (accept) begin
            st_d.busy = 1'b1;
            st_d.lane = '0;
            st_d.last = in_last;
            st_d.beat = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    qwb_lane_mux u_mux (
        .beat (st_q.beat),
        .sel  (st_q.lane),
        .word (wr_data)
    );

    qwb_addr_gen #(
        .ADDR_W    (ADDR_W),
        .STEP      (BE_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (st_q.busy),
        .rewind (rewind),
        .addr   (wr_addr)
    );

    assign in_ready = !st_q.busy;
    assign wr_en    = st_q.busy;
    assign wr_be    = {BE_W{st_q.busy}};
    assign wr_id    = REQ_ID;

endmodule

// File: rtl/qwb_checker.sv
module qwb_checker
    import qwb_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                ID_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter logic [ID_W-1:0]   REQ_ID    = 8'd3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BE_W-1:0]   wr_be,
    input logic [ID_W-1:0]   wr_id
);

    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !in_ready);

    p_full_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_be == {BE_W{1'b1}}));

    p_req_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_id == REQ_ID));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(BE_W)));

    p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> wr_en);

    p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[1:0] == BASE_ADDR[1:0]));

endmodule

bind qw_word_bridge qwb_checker #(
    .ADDR_W    (ADDR_W),
    .ID_W      (ID_W),
    .BASE_ADDR (BASE_ADDR),
    .REQ_ID    (REQ_ID)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_be    (wr_be),
    .wr_id    (wr_id)
);

// File: tb/sim_qw_word_bridge.sv
`timescale 1ns/1ps
module sim_qw_word_bridge;

    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [7:0]  RID  = 8'd3;
    localparam int          NVEC = 6;

    // {last, beat}
    localparam logic [128:0] VEC [NVEC] = '{
        {1'b0, 128'hFEEDFEED_FACEFACE_CAFECAFE_BEEFBEEF},
        {1'b1, 128'h88888888_77777777_66666666_55555555},
        {1'b1, 128'h0000000D_0000000C_0000000B_0000000A},
        {1'b0, 128'h13579BDF_2468ACE0_DEADBEEF_01234567},
        {1'b0, 128'hFFFFFFFF_00000000_FFFFFFFF_00000000},
        {1'b1, 128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] in_data;
    logic         in_last;
    logic         in_ready;
    logic         wr_en;
    logic [31:0]  wr_addr;
    logic [31:0]  wr_data;
    logic [3:0]   wr_be;
    logic [7:0]   wr_id;

    int          errors = 0;
    int          checks = 0;
    logic [31:0] exp_addr;

    always #10 clk = ~clk;

    qw_word_bridge #(.BASE_ADDR(BASE), .REQ_ID(RID)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .wr_id(wr_id)
    );

    task automatic chk(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check one write cycle against the model.
    task automatic chk_write(input logic [127:0] beat, input int lane);
        chk(wr_en === 1'b1, "R2 strobe", 128'(wr_en), 128'd1);
        chk(wr_data === beat[lane*32 +: 32], "R3/R10 lane data", 128'(wr_data),
            128'(beat[lane*32 +: 32]));
        chk(wr_addr === exp_addr, "R4/R8 address", 128'(wr_addr), 128'(exp_addr));
        chk(wr_be === 4'hF, "R5 byte enables", 128'(wr_be), 128'hF);
        chk(wr_id === RID, "R6 requester id", 128'(wr_id), 128'(RID));
        chk(in_ready === 1'b0, "R7 ready low while busy", 128'(in_ready), 128'd0);
        exp_addr = exp_addr + 32'd4;
    endtask

    task automatic chk_idle();
        chk(wr_en === 1'b0, "R9 no strobe when idle", 128'(wr_en), 128'd0);
        chk(in_ready === 1'b1, "R7 ready back after four writes", 128'(in_ready), 128'd1);
    endtask

    // Offer one beat, drop valid and scramble the bus after acceptance (R10).
    task automatic send_beat(input logic [127:0] beat, input logic last);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = beat;
        in_last  = last;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~beat;
        in_last  = ~last;
        for (int l = 0; l < 4; l++) begin
            chk_write(beat, l);
            @(negedge clk);
        end
        chk_idle();
        if (last) exp_addr = BASE;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        in_last  = 1'b0;
        exp_addr = BASE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready === 1'b1, "R1 ready after reset", 128'(in_ready), 128'd1);
        chk(wr_en === 1'b0, "R1 no strobe after reset", 128'(wr_en), 128'd0);

        // Table walk: three packets (R2..R8, R10)
        for (int v = 0; v < NVEC; v++) begin
            send_beat(VEC[v][127:0], VEC[v][128]);
        end

        // R9: idle with no valid for several cycles
        repeat (3) begin
            @(negedge clk);
            chk(wr_en === 1'b0, "R9 idle without input", 128'(wr_en), 128'd0);
        end

        // R7/R10: valid held high with a second beat during the busy period
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = VEC[0][127:0];
        in_last  = 1'b0;
        @(negedge clk);
        in_data  = VEC[3][127:0];
        in_last  = 1'b1;
        for (int l = 0; l < 4; l++) begin
            chk_write(VEC[0][127:0], l);
            @(negedge clk);
        end
        chk_idle();
        @(negedge clk);
        in_valid = 1'b0;
        for (int l = 0; l < 4; l++) begin
            chk_write(VEC[3][127:0], l);
            @(negedge clk);
        end
        chk_idle();
        exp_addr = BASE;

        // R8/R1: reset in the middle of a packet returns address to base
        send_beat(VEC[4][127:0], 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_addr = BASE;
        @(negedge clk);
        chk(in_ready === 1'b1, "R1 ready after mid-packet reset", 128'(in_ready), 128'd1);
        send_beat(VEC[5][127:0], 1'b1);

        // R8: a fresh packet after a last beat starts at base
        send_beat(VEC[2][127:0], 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule